// File: doc/BRIEF.md
# Eight-Channel Timer Control Register Bank

This block is the register front end for a group of eight timer channels. A 32-bit word bus reaches each channel's count, reload value and two compare values. One packed control word holds a 4-bit field per channel: run, external clock select, overflow interrupt enable and pulse mode. The counters sit outside the block. The bank gives each counter its settings and a load strobe, and takes back each counter's live count and its interrupt events.

When a control update stops a channel, the run output falls first and the other settings follow one cycle later. When an update starts a channel, the settings change first and the run output rises one cycle later. A counter therefore never runs under a half-applied configuration. A second way to change the control word clears control bits by mask. It works only after a command byte has unlocked it. A shared status word collects the channel interrupt events, and software clears its bits by writing ones.

Top module: `tmr_ctrl_bank`

## Requirements
- R1: Channel registers use address bits [7:4]. A value of 0, 1 or 2 selects channel 0, 1 or 2. A value of 4 to 8 selects channel (value − 1). Address bits [3:2] pick the word within the channel: 1 is reload, 2 is first compare and 3 is second compare. These three words are held in the block, read back as written and appear on `reload_o`, `match1_o` and `match2_o`.
- R2: Word 0 of a channel is its status. A read returns that channel's `cnt_i` slice. A write pulses that channel's `load_o` bit for exactly one cycle, with the written value on `load_val_o`.
- R3: The control word is at 0x30 and reads back as written. Channel i owns bits [4i+3:4i]: bit 0 is run, bit 1 is external clock, bit 2 is overflow interrupt enable and bit 3 is pulse mode.
- R4: `pulse_o` is always 0 for channels 0 to 3, whatever their pulse-mode bit holds.
- R5: When a channel's run bit goes from 1 to 0, `en_o` falls in the cycle after the write. `extclk_o`, `ovfie_o` and `pulse_o` keep their old values for that cycle and take the new ones one cycle later.
- R6: When a channel's run bit goes from 0 to 1, the other three outputs take their new values in the cycle after the write, and `en_o` rises one cycle after that.
- R7: A write to 0x38 with data bits [8:1] = 0xAE sets the unlock flag, and 0xEA clears it. Any other value leaves the flag unchanged. A read of 0x38 returns the flag in bit 0.
- R8: A write to 0x3C while the flag is set clears every control bit whose mask bit is 1, with the R5/R6 ordering. While the flag is clear the write is ignored.
- R9: Bit i of the word at 0x34 is set by a one-cycle pulse on `evt_i[i]`. Writing a 1 to the bit clears it. A new event wins over a clear in the same cycle.
- R10: An access with address bits [1:0] ≠ 0, or to any address not named above (0x3C reads, 0x90 and above), reads as zero and changes nothing when written.
- R11: `bus_rvalid` is high in the cycle after each read request. `bus_rdata` is valid in that cycle and zero in all other cycles.
- R12: After reset every register, the unlock flag and the interrupt status read as zero, and all channel outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| cnt_i | input | 8*DW | Live count of each channel |
| evt_i | input | 8 | Per-channel interrupt event pulses |
| en_o | output | 8 | Channel run |
| extclk_o | output | 8 | External clock select |
| ovfie_o | output | 8 | Overflow interrupt enable |
| pulse_o | output | 8 | Pulse mode (channels 4 to 7 only) |
| load_o | output | 8 | One-cycle count load strobe |
| load_val_o | output | DW | Value to load |
| reload_o | output | 8*DW | Reload value of each channel |
| match1_o | output | 8*DW | First compare value of each channel |
| match2_o | output | 8*DW | Second compare value of each channel |

## Verification
The bound checker watches several rules on every cycle. It checks that a falling run output never lands in the same cycle as a settings change, and that a start keeps the run output low for one cycle. It also checks that pulse mode stays off on the low four channels, that a locked mask write leaves the control word alone, that events always reach the status word, and that misaligned reads return zero. Other behaviour appears only in the bench's scenarios: whole unlock/clear/relock sequences, event-versus-clear collisions, the offset map around the gap at 0x30–0x3C, and status reads of a running counter stub. A behavioural model in the bench follows every output on every cycle.

// File: rtl/tmr_ctrl_bank.sv
module tmr_ctrl_bank #(
  parameter int DW = 32,
  parameter int FIRST_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic [8*DW-1:0]   cnt_i,
  input  logic [7:0]        evt_i,
  output logic [7:0]        en_o,
  output logic [7:0]        extclk_o,
  output logic [7:0]        ovfie_o,
  output logic [7:0]        pulse_o,
  output logic [7:0]        load_o,
  output logic [DW-1:0]     load_val_o,
  output logic [8*DW-1:0]   reload_o,
  output logic [8*DW-1:0]   match1_o,
  output logic [8*DW-1:0]   match2_o
);
  localparam int NCH = 8;
  localparam int CW  = 4 * NCH;

  logic [DW-1:0] rl_q [NCH];
  logic [DW-1:0] m1_q [NCH];
  logic [DW-1:0] m2_q [NCH];
  logic [CW-1:0] ctrl_q, prev_q, ctrl_d;
  logic          unlock_q;
  logic [NCH-1:0] irq_q;
  logic [DW-1:0] rd_mux;

  wire       wr      = bus_sel & bus_wr;
  wire       rd      = bus_sel & ~bus_wr;
  wire       aligned = bus_addr[1:0] == 2'b00;
  wire [3:0] blk     = bus_addr[7:4];
  wire [1:0] wsel    = bus_addr[3:2];
  wire       chan_hit = aligned && (blk <= 4'd2 || (blk >= 4'd4 && blk <= 4'd8));
  wire       shr_hit  = aligned && blk == 4'd3;
  wire [3:0] chan_w   = (blk <= 4'd2) ? blk : blk - 4'd1;
  wire [2:0] chan     = chan_w[2:0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr && shr_hit && wsel == 2'd0)
      ctrl_d = bus_wdata[CW-1:0];
    else if (wr && shr_hit && wsel == 2'd3 && unlock_q)
      ctrl_d = ctrl_q & ~bus_wdata[CW-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (chan_hit) begin
      case (wsel)
        2'd0: rd_mux = cnt_i[int'(chan)*DW +: DW];
        2'd1: rd_mux = rl_q[chan];
        2'd2: rd_mux = m1_q[chan];
        default: rd_mux = m2_q[chan];
      endcase
    end else if (shr_hit) begin
      case (wsel)
        2'd0: rd_mux[CW-1:0]  = ctrl_q;
        2'd1: rd_mux[NCH-1:0] = irq_q;
        2'd2: rd_mux[0]       = unlock_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      prev_q     <= '0;
      unlock_q   <= 1'b0;
      irq_q      <= '0;
      load_o     <= '0;
      load_val_o <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        rl_q[i] <= '0;
        m1_q[i] <= '0;
        m2_q[i] <= '0;
      end
    end else begin
      ctrl_q     <= ctrl_d;
      prev_q     <= ctrl_q;
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
      load_o     <= '0;
      irq_q      <= (irq_q & ~((wr && shr_hit && wsel == 2'd1) ? bus_wdata[NCH-1:0] : '0)) | evt_i;
      if (wr && shr_hit && wsel == 2'd2) begin
        if (bus_wdata[8:1] == 8'hAE)      unlock_q <= 1'b1;
        else if (bus_wdata[8:1] == 8'hEA) unlock_q <= 1'b0;
      end
      if (wr && chan_hit) begin
        case (wsel)
          2'd0: begin
            load_o[chan] <= 1'b1;
            load_val_o   <= bus_wdata;
          end
          2'd1: rl_q[chan] <= bus_wdata;
          2'd2: m1_q[chan] <= bus_wdata;
          default: m2_q[chan] <= bus_wdata;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire       stopping = prev_q[4*i] & ~ctrl_q[4*i];
    wire [3:0] cfg      = stopping ? prev_q[4*i +: 4] : ctrl_q[4*i +: 4];
    assign en_o[i]     = ctrl_q[4*i] & prev_q[4*i];
    assign extclk_o[i] = cfg[1];
    assign ovfie_o[i]  = cfg[2];
    if (i >= FIRST_PULSE) begin : g_pl
      assign pulse_o[i] = cfg[3];
    end else begin : g_np
      assign pulse_o[i] = 1'b0;
    end
    assign reload_o[i*DW +: DW] = rl_q[i];
    assign match1_o[i*DW +: DW] = m1_q[i];
    assign match2_o[i*DW +: DW] = m2_q[i];
  end
endmodule

// File: rtl/tmr_ctrl_bank_chk.sv
module tmr_ctrl_bank_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_rvalid,
  input logic [7:0]    evt_i,
  input logic [7:0]    en_o,
  input logic [7:0]    extclk_o,
  input logic [7:0]    ovfie_o,
  input logic [7:0]    pulse_o,
  input logic [31:0]   ctrl_q,
  input logic          unlock_q,
  input logic [7:0]    irq_q
);
  p_rd_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

  p_locked_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h3C && !unlock_q) |=> $stable(ctrl_q));

  p_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h38 && bus_wdata[8:1] == 8'hAE) |=> unlock_q);

  p_no_pulse_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o[3:0] == 4'b0000);

  for (genvar i = 0; i < 8; i++) begin : g_c
    p_evt_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> irq_q[i]);

    p_off_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o[i]) |-> $stable({extclk_o[i], ovfie_o[i], pulse_o[i]}));

    p_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == 8'h30 && bus_wdata[4*i] && !ctrl_q[4*i])
        |=> (!en_o[i] && ctrl_q[4*i]));
  end
endmodule

bind tmr_ctrl_bank tmr_ctrl_bank_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .evt_i(evt_i), .en_o(en_o), .extclk_o(extclk_o),
  .ovfie_o(ovfie_o), .pulse_o(pulse_o), .ctrl_q(ctrl_q), .unlock_q(unlock_q),
  .irq_q(irq_q)
);

// File: tb/tmr_ctrl_bank_tb.sv
module tmr_ctrl_bank_tb;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, load_val_o;
  logic bus_rvalid;
  logic [255:0] cnt_i, reload_o, match1_o, match2_o;
  logic [7:0] evt_i = 0, en_o, extclk_o, ovfie_o, pulse_o, load_o;

  always #4 clk = ~clk;

  tmr_ctrl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cnt_i(cnt_i), .evt_i(evt_i), .en_o(en_o),
    .extclk_o(extclk_o), .ovfie_o(ovfie_o), .pulse_o(pulse_o), .load_o(load_o),
    .load_val_o(load_val_o), .reload_o(reload_o), .match1_o(match1_o),
    .match2_o(match2_o)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // counter stubs
  logic [31:0] stub [8];
  always_comb for (int i = 0; i < 8; i++) cnt_i[i*32 +: 32] = stub[i];

  // behavioural reference model
  logic [31:0] mc, mp, mrl [8], mm1 [8], mm2 [8], erd, elv;
  logic [7:0] mi, eld;
  bit mu, erv, mdl_on;

  function automatic int chan_of(input logic [7:0] a);
    int k;
    if (a % 4 != 0) return -1;
    k = a / 16;
    if (k < 3) return k;
    if (k >= 4 && k <= 8) return k - 1;
    return -1;
  endfunction

  function automatic logic [31:0] read_val(input logic [7:0] a);
    int c;
    c = chan_of(a);
    if (c >= 0) begin
      case ((a % 16) / 4)
        0: return stub[c];
        1: return mrl[c];
        2: return mm1[c];
        default: return mm2[c];
      endcase
    end
    if (a == 8'h30) return mc;
    if (a == 8'h34) return {24'b0, mi};
    if (a == 8'h38) return {31'b0, mu};
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] nc;
    int c;
    mdl_on = 1;
    if (!rst_n) begin
      mc = 0; mp = 0; mu = 0; mi = 0; erd = 0; erv = 0; eld = 0; elv = 0;
      for (int i = 0; i < 8; i++) begin mrl[i] = 0; mm1[i] = 0; mm2[i] = 0; end
    end else begin
      c = chan_of(bus_addr);
      erv = bus_sel && !bus_wr;
      erd = erv ? read_val(bus_addr) : 0;
      eld = 0;
      nc = mc;
      if (bus_sel && bus_wr) begin
        if (c >= 0) begin
          case ((bus_addr % 16) / 4)
            0: begin eld[c] = 1; elv = bus_wdata; end
            1: mrl[c] = bus_wdata;
            2: mm1[c] = bus_wdata;
            default: mm2[c] = bus_wdata;
          endcase
        end else if (bus_addr == 8'h30) nc = bus_wdata;
        else if (bus_addr == 8'h34) mi = mi & ~bus_wdata[7:0];
        else if (bus_addr == 8'h38) begin
          if (bus_wdata[8:1] == 8'hAE) mu = 1;
          else if (bus_wdata[8:1] == 8'hEA) mu = 0;
        end else if (bus_addr == 8'h3C && mu) nc = mc & ~bus_wdata;
      end
      mi = mi | evt_i;
      mp = mc;
      mc = nc;
    end
  end

  // per-cycle comparison, then stub update
  always @(negedge clk) begin
    if (mdl_on) begin
      chk(bus_rvalid == erv, "R11 rvalid", {31'b0, bus_rvalid}, {31'b0, erv});
      chk(bus_rdata == erd, "R1/R2/R3 rdata", bus_rdata, erd);
      chk(load_o == eld, "R2 load", {24'b0, load_o}, {24'b0, eld});
      if (|eld) chk(load_val_o == elv, "R2 load_val", load_val_o, elv);
      for (int i = 0; i < 8; i++) begin
        logic [3:0] src;
        bit e;
        e = mc[4*i] && mp[4*i];
        src = (mp[4*i] && !mc[4*i]) ? mp[4*i +: 4] : mc[4*i +: 4];
        chk(en_o[i] == e, "R5/R6 en", {24'b0, en_o}, i);
        chk(extclk_o[i] == src[1] && ovfie_o[i] == src[2], "R5/R6 cfg",
            {16'b0, extclk_o, ovfie_o}, {28'b0, src});
        chk(pulse_o[i] == (i >= 4 ? src[3] : 1'b0), "R4 pulse", {24'b0, pulse_o}, {28'b0, src});
        chk(reload_o[i*32 +: 32] == mrl[i] && match1_o[i*32 +: 32] == mm1[i] &&
            match2_o[i*32 +: 32] == mm2[i], "R1 outputs", reload_o[i*32 +: 32], mrl[i]);
      end
    end
    for (int i = 0; i < 8; i++) begin
      if (!rst_n) stub[i] = 32'h0;
      else if (load_o[i]) stub[i] = load_val_o;
      else if (en_o[i]) stub[i] = stub[i] - 1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; evt_i = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(bus_rvalid && bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(en_o == 0 && load_o == 0 && pulse_o == 0, "R12 outputs", {24'b0, en_o}, 0);
    rd_chk(8'h30, 32'h0, "R12 ctrl");
    rd_chk(8'h34, 32'h0, "R12 irq");
    rd_chk(8'h14, 32'h0, "R12 reload");

    // R1 map
    wr(8'h04, 32'h1234);
    wr(8'h84, 32'hCAFE);
    wr(8'h48, 32'h55);
    wr(8'h2C, 32'h77);
    rd_chk(8'h04, 32'h1234, "R1 ch0 reload");
    rd_chk(8'h84, 32'hCAFE, "R1 ch7 reload");
    rd_chk(8'h48, 32'h55, "R1 ch3 match1");
    rd_chk(8'h2C, 32'h77, "R1 ch2 match2");
    chk(reload_o[7*32 +: 32] == 32'hCAFE, "R1 reload_o", reload_o[7*32 +: 32], 32'hCAFE);

    // R2 status load
    wr(8'h50, 32'd100);
    rd_chk(8'h50, 32'd100, "R2 status ch4");

    // R6 enable ordering
    wr(8'h30, 32'h7);
    chk(en_o[0] == 0 && ovfie_o[0] == 1 && extclk_o[0] == 1, "R6 cfg first",
        {24'b0, en_o}, 32'h0);
    @(negedge clk);
    chk(en_o[0] == 1, "R6 enable later", {24'b0, en_o}, 32'h1);
    repeat (5) @(negedge clk);

    // R5 disable ordering
    wr(8'h30, 32'h0);
    chk(en_o[0] == 0 && ovfie_o[0] == 1, "R5 disable first", {24'b0, ovfie_o}, 32'h1);
    @(negedge clk);
    chk(ovfie_o[0] == 0 && extclk_o[0] == 0, "R5 cfg later", {24'b0, ovfie_o}, 32'h0);

    // R3, R4
    wr(8'h30, 32'h8888_8888);
    @(negedge clk);
    chk(pulse_o == 8'hF0, "R4 pulse gated", {24'b0, pulse_o}, 32'hF0);
    rd_chk(8'h30, 32'h8888_8888, "R3 readback");

    // R7, R8 lock
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h8888_8888, "R8 locked ignore");
    wr(8'h38, 32'hAE << 1);
    rd_chk(8'h38, 32'h1, "R7 unlock");
    wr(8'h38, 32'h55 << 1);
    rd_chk(8'h38, 32'h1, "R7 other value");
    wr(8'h3C, 32'h0000_0008);
    rd_chk(8'h30, 32'h8888_8880, "R8 mask clear");
    wr(8'h30, 32'h0000_0115);
    repeat (2) @(negedge clk);
    wr(8'h3C, 32'h0000_0101);
    chk(en_o[0] == 0 && ovfie_o[0] == 1, "R8 ordered clear", {24'b0, ovfie_o}, 32'h1);
    rd_chk(8'h30, 32'h0000_0014, "R8 mask result");
    wr(8'h38, 32'hEA << 1);
    rd_chk(8'h38, 32'h0, "R7 relock");

    // R9 irq status
    wr(8'h9C, 32'h0, 8'h81);
    rd_chk(8'h34, 32'h81, "R9 set");
    wr(8'h34, 32'h01);
    rd_chk(8'h34, 32'h80, "R9 w1c");
    wr(8'h34, 32'h80, 8'h80);
    rd_chk(8'h34, 32'h80, "R9 set wins");
    wr(8'h34, 32'hFF);
    rd_chk(8'h34, 32'h0, "R9 clear all");

    // R10 unmapped / misaligned
    rd_chk(8'h3C, 32'h0, "R10 read 3C");
    rd_chk(8'h90, 32'h0, "R10 read 90");
    wr(8'h05, 32'hFFFF);
    rd_chk(8'h06, 32'h0, "R10 misaligned read");
    rd_chk(8'h04, 32'h1234, "R10 misaligned write");
    wr(8'h31, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h0000_0014, "R10 misaligned ctrl");

    // running counter stub read
    wr(8'h30, 32'h0001_0000);
    repeat (4) @(negedge clk);
    rd_chk(8'h50, 32'd95, "R2 running status");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule